// File: doc/BRIEF.md
# Inbound Bus-Master Address Window Translator

This block sits between a PCI bus master and local memory and decides where each bus-master address lands. Software programs three inbound windows through a 32-bit register port. Each window has a 64-bit size/attribute word and a 64-bit local base. A lookup port takes a 64-bit PCI address and returns its result in the same cycle. The result is the window that claimed the address, the translated local address, and a flag that says the address bypassed every window.

Every window is anchored at PCI address zero and is aligned to its own size. An address belongs to an enabled window when it has no bit set under that window's mask. The translated address is the local base plus the PCI address. When no enabled window claims the address, it passes through unchanged to the identity view of bus memory. The windows always sit above that identity view in priority.

Register writes are captured on the clock edge. A lookup therefore uses the programming as it stands after the last completed write.

Top module: `ibw_translator`

## Requirements
- R1: After reset every local base reads 0. Every size word holds 0xFFFFFFFF_00000000, so the low halves read 0 and the high halves (offsets 0xF8, 0xFC) read 0xFFFFFFFF. The status word reads 0, and every lookup passes through.
- R2: Each 32-bit register is read back as written. Writing the low half of a 64-bit word leaves its high half unchanged, and writing the high half leaves the low half unchanged. Window 0 uses size 0x98/0xF8 and local 0x9C/0xA0. Window 1 uses size 0xA4 and local 0xA8/0xAC. Window 2 uses size 0xB0/0xFC and local 0xB4/0xB8. Each pair is listed as low/high.
- R3: Window 1 has a single size register at 0xA4. A write there replaces the whole 64-bit size word, with the upper 32 bits becoming 0.
- R4: A window takes part in lookups only while bit 0 of its size word is 1.
- R5: An enabled window claims address A when (A & M) == 0, where M is the size word with bits 2:0 forced to 0. Bits 2:1 of the size word never affect matching.
- R6: On a hit, loc_addr = local base + A, taken modulo 2^64.
- R7: When no enabled window claims A, win_hit is 0, passthru is 1 and loc_addr equals A.
- R8: When several enabled windows claim A, only the lowest-numbered one is reported. win_hit is one-hot (bit i = window i) and its translation is used.
- R9: The status register at 0xE0 is a plain 32-bit read/write word.
- R10: Reads of any offset not listed in R2, R3 or R9 return 0, and writes to such offsets change no register and no lookup result.
- R11: A register write takes effect at the clock edge that captures it. Before that edge, lookups still reflect the old programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| pci_addr | input | 64 | Bus-master address to translate |
| win_hit | output | 3 | One-hot window that claimed the address |
| loc_addr | output | 64 | Translated local address |
| passthru | output | 1 | Address bypassed all windows |

## Verification
The bench sweeps addresses on every power-of-two boundary, one below it, and with the top bit added. It does this across several window programmings and compares each result against an arithmetic model.

- A design that kept bits 2:1 in the mask would miss byte offsets 2 to 7 of a small window.
- A window-1 size write that kept the old high half would fail to claim addresses with upper bits set.
- Reversed priority shows up as the wrong one-hot bit and the wrong base wherever windows overlap.
- A base adder that dropped its carry handling, or a wrong reset of the size words, shows up as wrong translations or windows claiming addresses straight after reset.

// File: rtl/ibw_pkg.sv
package ibw_pkg;
    localparam int NWIN   = 3;
    localparam int AW     = 64;
    localparam int DW     = 32;
    localparam int OFFW   = 8;
    localparam int ATTR_W = 3;   // size-word bits ignored by the mask

    localparam logic [OFFW-1:0] OFF_W0_SZ_LO = 8'h98;
    localparam logic [OFFW-1:0] OFF_W0_SZ_HI = 8'hF8;
    localparam logic [OFFW-1:0] OFF_W0_BA_LO = 8'h9C;
    localparam logic [OFFW-1:0] OFF_W0_BA_HI = 8'hA0;
    localparam logic [OFFW-1:0] OFF_W1_SZ    = 8'hA4;
    localparam logic [OFFW-1:0] OFF_W1_BA_LO = 8'hA8;
    localparam logic [OFFW-1:0] OFF_W1_BA_HI = 8'hAC;
    localparam logic [OFFW-1:0] OFF_W2_SZ_LO = 8'hB0;
    localparam logic [OFFW-1:0] OFF_W2_SZ_HI = 8'hFC;
    localparam logic [OFFW-1:0] OFF_W2_BA_LO = 8'hB4;
    localparam logic [OFFW-1:0] OFF_W2_BA_HI = 8'hB8;
    localparam logic [OFFW-1:0] OFF_STS      = 8'hE0;

    localparam logic [AW-1:0] SIZE_RST = {{(AW-DW){1'b1}}, {DW{1'b0}}};

    typedef struct packed {
        logic [NWIN-1:0][AW-1:0] size;
        logic [NWIN-1:0][AW-1:0] base;
        logic [DW-1:0]           sts;
    } ibw_regs_t;
endpackage

// File: rtl/ibw_regfile.sv
module ibw_regfile
    import ibw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [OFFW-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output ibw_regs_t        regs
);
    ibw_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            case (reg_addr)
                OFF_W0_SZ_LO: st_d.size[0][DW-1:0]  = reg_wdata;
                OFF_W0_SZ_HI: st_d.size[0][AW-1:DW] = reg_wdata;
                OFF_W0_BA_LO: st_d.base[0][DW-1:0]  = reg_wdata;
                OFF_W0_BA_HI: st_d.base[0][AW-1:DW] = reg_wdata;
                OFF_W1_SZ:    st_d.size[1]          = {{(AW-DW){1'b0}}, reg_wdata};
                OFF_W1_BA_LO: st_d.base[1][DW-1:0]  = reg_wdata;
                OFF_W1_BA_HI: st_d.base[1][AW-1:DW] = reg_wdata;
                OFF_W2_SZ_LO: st_d.size[2][DW-1:0]  = reg_wdata;
                OFF_W2_SZ_HI: st_d.size[2][AW-1:DW] = reg_wdata;
                OFF_W2_BA_LO: st_d.base[2][DW-1:0]  = reg_wdata;
                OFF_W2_BA_HI: st_d.base[2][AW-1:DW] = reg_wdata;
                OFF_STS:      st_d.sts              = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWIN; i++) begin
                st_q.size[i] <= SIZE_RST;
                st_q.base[i] <= '0;
            end
            st_q.sts <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFF_W0_SZ_LO: reg_rdata = st_q.size[0][DW-1:0];
            OFF_W0_SZ_HI: reg_rdata = st_q.size[0][AW-1:DW];
            OFF_W0_BA_LO: reg_rdata = st_q.base[0][DW-1:0];
            OFF_W0_BA_HI: reg_rdata = st_q.base[0][AW-1:DW];
            OFF_W1_SZ:    reg_rdata = st_q.size[1][DW-1:0];
            OFF_W1_BA_LO: reg_rdata = st_q.base[1][DW-1:0];
            OFF_W1_BA_HI: reg_rdata = st_q.base[1][AW-1:DW];
            OFF_W2_SZ_LO: reg_rdata = st_q.size[2][DW-1:0];
            OFF_W2_SZ_HI: reg_rdata = st_q.size[2][AW-1:DW];
            OFF_W2_BA_LO: reg_rdata = st_q.base[2][DW-1:0];
            OFF_W2_BA_HI: reg_rdata = st_q.base[2][AW-1:DW];
            OFF_STS:      reg_rdata = st_q.sts;
            default:      reg_rdata = '0;
        endcase
    end

    assign regs = st_q;
endmodule

// File: rtl/ibw_win_match.sv
module ibw_win_match #(
    parameter int ADDR_W = 64,
    parameter int ATTR_W = 3
) (
    input  logic [ADDR_W-1:0] size_word,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] xlat
);
    logic [ADDR_W-1:0] mask;

    always_comb begin
        mask = {size_word[ADDR_W-1:ATTR_W], {ATTR_W{1'b0}}};
        hit  = size_word[0] && ((addr & mask) == '0);
        xlat = base + addr;
    end
endmodule

// File: rtl/ibw_select.sv
module ibw_select #(
    parameter int NWIN   = 3,
    parameter int ADDR_W = 64
) (
    input  logic [NWIN-1:0]             hits,
    input  logic [NWIN-1:0][ADDR_W-1:0] xlats,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NWIN-1:0]             win_hit,
    output logic [ADDR_W-1:0]           loc_addr,
    output logic                        passthru
);
    always_comb begin
        win_hit  = '0;
        loc_addr = addr;
        passthru = 1'b1;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                win_hit    = '0;
                win_hit[i] = 1'b1;
                loc_addr   = xlats[i];
                passthru   = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ibw_translator.sv
module ibw_translator
    import ibw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [OFFW-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic [AW-1:0]    pci_addr,
    output logic [NWIN-1:0]  win_hit,
    output logic [AW-1:0]    loc_addr,
    output logic             passthru
);
    ibw_regs_t                regs;
    logic [NWIN-1:0]          hits;
    logic [NWIN-1:0][AW-1:0]  xlats;

    ibw_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .regs      (regs)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        ibw_win_match #(.ADDR_W(AW), .ATTR_W(ATTR_W)) u_match (
            .size_word (regs.size[g]),
            .base      (regs.base[g]),
            .addr      (pci_addr),
            .hit       (hits[g]),
            .xlat      (xlats[g])
        );
    end

    ibw_select #(.NWIN(NWIN), .ADDR_W(AW)) u_sel (
        .hits     (hits),
        .xlats    (xlats),
        .addr     (pci_addr),
        .win_hit  (win_hit),
        .loc_addr (loc_addr),
        .passthru (passthru)
    );
endmodule

// File: rtl/ibw_checker.sv
module ibw_checker
    import ibw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [OFFW-1:0]  reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [DW-1:0]    reg_rdata,
    input logic [AW-1:0]    pci_addr,
    input logic [NWIN-1:0]  win_hit,
    input logic [AW-1:0]    loc_addr,
    input logic             passthru
);
    // R8: at most one window reported
    a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_hit));

    // R7: no window -> identity and flag
    a_r7_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit == '0) |-> (passthru && loc_addr == pci_addr));

    // R7: flag never raised together with a window
    a_r7_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        passthru |-> (win_hit == '0));

    // R11: without a write, a held address keeps its result
    a_r11_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_we) && $stable(pci_addr)) |-> ($stable(loc_addr) && $stable(win_hit)));

    // R9: status reads back the value written one cycle before
    a_r9_status_rw: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFF_STS) ##1 (reg_addr == OFF_STS) |-> reg_rdata == $past(reg_wdata));
endmodule

bind ibw_translator ibw_checker u_chk (.*);

// File: tb/tb_ibw_translator.sv
module tb_ibw_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] pci_addr = '0;
    logic [2:0]  win_hit;
    logic [63:0] loc_addr;
    logic        passthru;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] m_size [3];
    logic [63:0] m_base [3];
    logic [31:0] m_sts;

    always #10 clk = ~clk;

    ibw_translator dut (.*);

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h98: return m_size[0][31:0];
            8'hF8: return m_size[0][63:32];
            8'h9C: return m_base[0][31:0];
            8'hA0: return m_base[0][63:32];
            8'hA4: return m_size[1][31:0];
            8'hA8: return m_base[1][31:0];
            8'hAC: return m_base[1][63:32];
            8'hB0: return m_size[2][31:0];
            8'hFC: return m_size[2][63:32];
            8'hB4: return m_base[2][31:0];
            8'hB8: return m_base[2][63:32];
            8'hE0: return m_sts;
            default: return 32'h0;
        endcase
    endfunction

    function automatic bit mapped(input logic [7:0] a);
        return (a == 8'h98 || a == 8'hF8 || a == 8'h9C || a == 8'hA0 || a == 8'hA4 ||
                a == 8'hA8 || a == 8'hAC || a == 8'hB0 || a == 8'hFC || a == 8'hB4 ||
                a == 8'hB8 || a == 8'hE0);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        case (a)
            8'h98: m_size[0][31:0]  = d;
            8'hF8: m_size[0][63:32] = d;
            8'h9C: m_base[0][31:0]  = d;
            8'hA0: m_base[0][63:32] = d;
            8'hA4: m_size[1]        = {32'h0, d};
            8'hA8: m_base[1][31:0]  = d;
            8'hAC: m_base[1][63:32] = d;
            8'hB0: m_size[2][31:0]  = d;
            8'hFC: m_size[2][63:32] = d;
            8'hB4: m_base[2][31:0]  = d;
            8'hB8: m_base[2][63:32] = d;
            8'hE0: m_sts            = d;
            default: ;
        endcase
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== m_read(a)) begin
            n_bad++;
            $display("FAIL %s off=%h got=%h exp=%h", tag, a, reg_rdata, m_read(a));
        end
    endtask

    task automatic chk_lu(input string tag, input logic [63:0] a);
        logic [2:0]  eh;
        logic [63:0] el;
        logic        ep;
        eh = '0; el = a; ep = 1'b1;
        for (int i = 2; i >= 0; i--) begin
            if (m_size[i][0] && ((a & {m_size[i][63:3], 3'b000}) == 64'h0)) begin
                eh = 3'b001 << i; el = m_base[i] + a; ep = 1'b0;
            end
        end
        pci_addr = a;
        #1;
        n_chk++;
        if (win_hit !== eh || loc_addr !== el || passthru !== ep) begin
            n_bad++;
            $display("FAIL %s addr=%h got hit=%b loc=%h pt=%b exp hit=%b loc=%h pt=%b",
                     tag, a, win_hit, loc_addr, passthru, eh, el, ep);
        end
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 64; k++) begin
            chk_lu(tag, 64'd1 << k);
            chk_lu(tag, (64'd1 << k) - 64'd1);
            chk_lu(tag, (64'd1 << k) | 64'h8000_0000_0000_0000);
        end
        for (int k = 0; k < 8; k++) chk_lu(tag, 64'(k));
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 256; a += 4) chk_rd(tag, 8'(a));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_size[i] = 64'hFFFF_FFFF_0000_0000;
            m_base[i] = 64'h0;
        end
        m_sts = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9 reset values, R10 unmapped reads zero
        read_all("R1_reset");
        sweep("R1_R7_reset_passthru");

        // R2 halves independent
        wr(8'h9C, 32'h1111_2222); wr(8'hA0, 32'h3333_4444);
        wr(8'h9C, 32'h5555_6666);
        chk_rd("R2_low_write_keeps_high", 8'hA0);
        chk_rd("R2_low_readback", 8'h9C);
        wr(8'hF8, 32'h0F0F_0F0F);
        chk_rd("R2_high_write_keeps_low", 8'h98);
        chk_rd("R2_high_readback", 8'hF8);
        wr(8'hE0, 32'hDEAD_BEEF);
        chk_rd("R9_status", 8'hE0);
        wr(8'hE0, 32'h0000_0001);
        chk_rd("R9_status_rewrite", 8'hE0);

        // R10 unmapped writes have no effect
        for (int a = 0; a < 256; a += 4)
            if (!mapped(8'(a))) wr(8'(a), 32'hFFFF_FFFF);
        for (int a = 1; a < 256; a += 37) wr(8'(a), 32'hFFFF_FFFF);
        read_all("R10_unmapped");
        sweep("R10_lookup_unchanged");

        // R5/R6: window 0 of 64 KiB at local 0x1_0000_0000
        wr(8'hF8, 32'hFFFF_FFFF); wr(8'h98, 32'hFFFF_0001);
        wr(8'h9C, 32'h0000_0000); wr(8'hA0, 32'h0000_0001);
        sweep("R5_R6_win0");
        chk_lu("R6_win0_top", 64'h0000_0000_0000_FFFF);
        chk_lu("R7_win0_beyond", 64'h0000_0000_0001_0000);

        // R8: window 2 of 1 MiB overlapping window 0
        wr(8'hFC, 32'hFFFF_FFFF); wr(8'hB0, 32'hFFF0_0001);
        wr(8'hB4, 32'h8000_0000); wr(8'hB8, 32'h0);
        sweep("R8_overlap_low_wins");
        chk_lu("R8_w0_over_w2", 64'h0000_0000_0000_1234);
        chk_lu("R8_only_w2", 64'h0000_0000_0008_0000);

        // R5: bits 2:1 of the size word are ignored (8-byte window)
        wr(8'h98, 32'hFFFF_0000);
        wr(8'hB0, 32'hFFFF_FFF7);
        for (int k = 0; k < 16; k++) chk_lu("R5_attr_bits_ignored", 64'(k));

        // R4: enable bit controls participation
        wr(8'hB0, 32'hFFFF_FFF6);
        chk_lu("R4_disabled_w2", 64'h6);
        chk_lu("R4_disabled_w2_zero", 64'h0);

        // R3: single size word of window 1 clears its upper half
        wr(8'hA8, 32'h0000_1000); wr(8'hAC, 32'h0000_0002);
        wr(8'hA4, 32'hF000_0001);
        chk_rd("R3_w1_size_readback", 8'hA4);
        chk_lu("R3_w1_high_bits_hit", 64'hABCD_0000_0000_1000);
        chk_lu("R3_w1_low_miss", 64'hABCD_0000_1000_0000);
        sweep("R3_w1_sweep");

        // R6: 64-bit wrap of the local base sum
        wr(8'hA4, 32'h0000_0000);
        wr(8'h98, 32'hFFFF_0001);
        wr(8'h9C, 32'hFFFF_FFF0); wr(8'hA0, 32'hFFFF_FFFF);
        chk_lu("R6_wrap", 64'h20);
        sweep("R6_wrap_sweep");

        // R11: write visible only after its capturing edge
        pci_addr = 64'h40;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h98; reg_wdata = 32'hFFFF_0000;
        #2;
        n_chk++;
        if (win_hit !== 3'b001) begin
            n_bad++;
            $display("FAIL R11 before edge got hit=%b exp hit=001", win_hit);
        end
        m_size[0][31:0] = 32'hFFFF_0000;
        @(negedge clk);
        reg_we = 1'b0;
        chk_lu("R11_after_edge", 64'h40);

        // R1 again: reset restores defaults
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            m_size[i] = 64'hFFFF_FFFF_0000_0000;
            m_base[i] = 64'h0;
        end
        m_sts = 32'h0;
        read_all("R1_rereset");
        sweep("R1_rereset_passthru");

        finish_run();
    end
endmodule